// File: doc/BRIEF.md
# EEPROM Write-and-Poll Bus Master

This block sits on the host side of a byte-wide parallel bus that connects to a self-timed EEPROM. A client hands it one request: a start address, a byte count and a polling mode. The block then pulls the data bytes from a streaming input and drives one write cycle per byte on the bus, using chip-select, write-strobe and output-enable lines. When the last byte has been loaded, the device starts programming on its own and the master begins to poll it.

Polling uses ordinary read cycles. In data-bit mode the master re-reads the last address it wrote and waits until the top data bit matches the top bit of the last byte it wrote. In toggle mode it compares the second-highest bit of two reads in a row and waits until that bit stops flipping. When polling succeeds the master gives a one-cycle `done` pulse. If it gives up after a set number of reads, it gives a one-cycle `timeout` pulse instead. A request that would cross a page boundary is refused with a one-cycle `reject` pulse, and no bus cycle is run for it.

The bus timing is set by parameters in clock cycles: setup before the strobe, strobe width, and hold after it. The master drives the data bus only during write cycles, so it never drives the bus while the device might be driving it.

Top module: `ewp_master`

## Requirements
- R1: After reset, chip-select, write strobe and output enable are all high, `mem_dq_oe` is low, `req_ready` is high, `in_ready` is low and none of `done`, `timeout`, `reject` is asserted.
- R2: A request is accepted only when `req_len` is from 1 to PAGE_BYTES and (`req_addr` modulo PAGE_BYTES) + `req_len` is at most PAGE_BYTES. Any other request gets a one-cycle `reject` pulse, with no write strobe, no read strobe and no `in_ready`.
- R3: Each byte is written as follows. Address and data are driven with `mem_dq_oe` high, chip-select low and output enable high. The write strobe goes low for exactly PULSE_CYC cycles after SETUP_CYC cycles of setup. Address and data are then held for HOLD_CYC cycles after the strobe rises. Successive bytes go to successive addresses.
- R4: When the data stream has a byte ready, the write strobe falls every 1+SETUP_CYC+PULSE_CYC+HOLD_CYC cycles within a page. This spacing must stay below LOAD_WIN_CYC.
- R5: Whenever output enable is low, `mem_dq_oe` is low, the write strobe is high and chip-select is low. `mem_dq_oe` is already low in the cycle before output enable falls.
- R6: In data-bit mode (`req_toggle`=0), the master reads the last written address until bit 7 of the read byte equals bit 7 of the last written byte, and then pulses `done`.
- R7: In toggle mode (`req_toggle`=1), `done` follows the first read whose bit 6 equals bit 6 of the read just before it. `done` never follows a single read.
- R8: After POLL_LIMIT reads that do not meet the completion rule, the master pulses `timeout`, does not pulse `done`, and returns to idle.
- R9: `done`, `timeout` and `reject` each last one cycle and are mutually exclusive. `req_ready` is low whenever chip-select is low.
- R10: `in_ready` is high only while the master waits for the next byte. Exactly `req_len` bytes are taken from the stream and written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Master idle, request taken |
| req_addr | input | AW | First byte address |
| req_len | input | LENW | Byte count (1..PAGE_BYTES) |
| req_toggle | input | 1 | 1 = toggle polling, 0 = data-bit polling |
| in_valid | input | 1 | Stream byte present |
| in_ready | output | 1 | Stream byte taken |
| in_data | input | DW | Stream byte |
| mem_addr | output | AW | Bus address |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_dq_out | output | DW | Data driven onto the bus |
| mem_dq_oe | output | 1 | Bus driver enable |
| mem_dq_in | input | DW | Data read from the bus |
| done | output | 1 | Write finished pulse |
| timeout | output | 1 | Polling gave up pulse |
| reject | output | 1 | Request refused pulse |

## Verification
The bench runs single-byte writes whose top bit is 0 and whose top bit is 1 against a device model that stays busy for a set number of reads. This separates a correct data-bit comparison from an inverted one, and also separates a stale read address from the correct one. A multi-byte toggle-mode page, and a toggle run with no busy reads, show whether completion waits for two equal reads. A full aligned page shows that the boundary test accepts its upper limit, while requests that overflow a page, have zero length, or are one byte too long show that the rejection path runs no bus cycle. A device that never finishes checks the read count at which the master gives up.

// File: rtl/ewp_pkg.sv
// Shared types for the EEPROM write-and-poll master.
// Assumes: nothing beyond the encoding defined here.
package ewp_pkg;

    // Controller phases; each bus phase has a timed duration.
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_FETCH = 3'd1,
        ST_WSET  = 3'd2,
        ST_WSTR  = 3'd3,
        ST_WHLD  = 3'd4,
        ST_RSET  = 3'd5,
        ST_RSTR  = 3'd6,
        ST_RHLD  = 3'd7
    } ewp_state_e;

endpackage

// File: rtl/ewp_phase_timer.sv
// Down-counter that sets how long a bus phase lasts.
// Loading value N makes the phase last N+1 cycles; last is high in its final cycle.
// Assumes: the load is applied on the cycle before the phase begins.
module ewp_phase_timer #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         last
);

    logic [W-1:0] cnt_q;

    // Count down the current phase and reload on entry to a new phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - W'(1);
        end
    end

    assign last = (cnt_q == '0);

endmodule

// File: rtl/ewp_page_check.sv
// Decides whether a request fits inside one device page.
// Assumes: PAGE_BYTES is a power of two. Only the in-page offset of the address is supplied.
module ewp_page_check #(
    parameter  int PAGE_BYTES = 64,
    localparam int PGW        = $clog2(PAGE_BYTES),
    localparam int LENW       = PGW + 1
) (
    input  logic [PGW-1:0]  offset,
    input  logic [LENW-1:0] len,
    output logic            fits
);

    logic [LENW:0] end_pos;

    // One past the last byte offset; must not pass the page end.
    assign end_pos = {2'b00, offset} + {1'b0, len};
    assign fits    = (len != '0) && (end_pos <= (LENW + 1)'(PAGE_BYTES));

endmodule

// File: rtl/ewp_poll_judge.sv
// Applies the completion rule to each polled read.
// In data mode, completion means the top bit matches the last written top bit.
// In toggle mode, completion means bit 6 matches the previous read.
// Assumes: clear is held while idle, so a new poll series starts with no previous read.
module ewp_poll_judge #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          toggle_mode,
    input  logic          ref_top,
    input  logic          sample_en,
    input  logic [DW-1:0] sample,
    output logic          hit
);

    logic prev_tog_q;
    logic have_prev_q;
    logic unused_low_bits;

    // Keep the toggle bit of the last read and whether one exists.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            prev_tog_q  <= 1'b0;
            have_prev_q <= 1'b0;
        end else if (sample_en) begin
            prev_tog_q  <= sample[DW-2];
            have_prev_q <= 1'b1;
        end
    end

    // Completion test on the byte currently on the bus.
    always_comb begin
        if (toggle_mode) begin
            hit = have_prev_q && (prev_tog_q == sample[DW-2]);
        end else begin
            hit = (sample[DW-1] == ref_top);
        end
    end

    assign unused_low_bits = ^sample[DW-3:0];

endmodule

// File: rtl/ewp_master.sv
// Host-side master that loads a byte or page into a self-timed EEPROM and polls for completion.
// Takes one request on a valid/ready handshake, pulls the bytes from a stream,
// runs timed write cycles, then runs read cycles until the completion rule holds
// or the read limit is reached.
// Assumes: all timing parameters are at least 1 and the stream keeps pace with the byte-load window.
module ewp_master
    import ewp_pkg::*;
#(
    parameter  int AW           = 11,
    parameter  int DW           = 8,
    parameter  int PAGE_BYTES   = 64,
    parameter  int SETUP_CYC    = 2,
    parameter  int PULSE_CYC    = 3,
    parameter  int HOLD_CYC     = 1,
    parameter  int LOAD_WIN_CYC = 10000,
    parameter  int POLL_LIMIT   = 4096,
    localparam int PGW          = $clog2(PAGE_BYTES),
    localparam int LENW         = PGW + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [AW-1:0]   req_addr,
    input  logic [LENW-1:0] req_len,
    input  logic            req_toggle,
    input  logic            in_valid,
    output logic            in_ready,
    input  logic [DW-1:0]   in_data,
    output logic [AW-1:0]   mem_addr,
    output logic            mem_ce_n,
    output logic            mem_oe_n,
    output logic            mem_we_n,
    output logic [DW-1:0]   mem_dq_out,
    output logic            mem_dq_oe,
    input  logic [DW-1:0]   mem_dq_in,
    output logic            done,
    output logic            timeout,
    output logic            reject
);

    localparam int TMAX_A = (SETUP_CYC > PULSE_CYC) ? SETUP_CYC : PULSE_CYC;
    localparam int TMAX   = (TMAX_A > HOLD_CYC) ? TMAX_A : HOLD_CYC;
    localparam int TW     = (TMAX > 1) ? $clog2(TMAX) : 1;
    localparam int PCW    = $clog2(POLL_LIMIT + 1);
    localparam int BYTE_PERIOD = 1 + SETUP_CYC + PULSE_CYC + HOLD_CYC;

    // Reject parameter sets that break the bus timing rules.
    generate
        if (SETUP_CYC < 1 || PULSE_CYC < 1 || HOLD_CYC < 1) begin : g_bad_timing
            $error("ewp_master: phase lengths must be at least one cycle");
        end
        if (BYTE_PERIOD >= LOAD_WIN_CYC) begin : g_bad_window
            $error("ewp_master: byte period does not fit inside the load window");
        end
    endgenerate

    ewp_state_e       state_q, state_d;
    logic [AW-1:0]    cur_addr_q;
    logic [DW-1:0]    last_data_q;
    logic [LENW-1:0]  left_q;
    logic             mode_tog_q;
    logic [PCW-1:0]   poll_cnt_q;
    logic             met_q;
    logic             done_q, tmo_q, rej_q;

    logic             page_ok;
    logic             tmr_load, tmr_last;
    logic [TW-1:0]    tmr_val;
    logic             judge_hit;
    logic             sample_en;
    logic             at_limit;

    ewp_page_check #(
        .PAGE_BYTES (PAGE_BYTES)
    ) u_page (
        .offset (req_addr[PGW-1:0]),
        .len    (req_len),
        .fits   (page_ok)
    );

    ewp_phase_timer #(
        .W (TW)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .last     (tmr_last)
    );

    assign sample_en = (state_q == ST_RSTR) && tmr_last;

    ewp_poll_judge #(
        .DW (DW)
    ) u_judge (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (state_q == ST_IDLE),
        .toggle_mode (mode_tog_q),
        .ref_top     (last_data_q[DW-1]),
        .sample_en   (sample_en),
        .sample      (mem_dq_in),
        .hit         (judge_hit)
    );

    assign at_limit = (poll_cnt_q == PCW'(POLL_LIMIT));

    // Next phase of the bus sequence.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:  if (req_valid && page_ok) state_d = ST_FETCH;
            ST_FETCH: if (in_valid) state_d = ST_WSET;
            ST_WSET:  if (tmr_last) state_d = ST_WSTR;
            ST_WSTR:  if (tmr_last) state_d = ST_WHLD;
            ST_WHLD:  if (tmr_last) state_d = (left_q == LENW'(1)) ? ST_RSET : ST_FETCH;
            ST_RSET:  if (tmr_last) state_d = ST_RSTR;
            ST_RSTR:  if (tmr_last) state_d = ST_RHLD;
            ST_RHLD:  if (tmr_last) state_d = (met_q || at_limit) ? ST_IDLE : ST_RSET;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Phase length loaded when a new phase is entered.
    always_comb begin
        tmr_load = (state_d != state_q);
        case (state_d)
            ST_WSET, ST_RSET: tmr_val = TW'(SETUP_CYC - 1);
            ST_WSTR, ST_RSTR: tmr_val = TW'(PULSE_CYC - 1);
            ST_WHLD, ST_RHLD: tmr_val = TW'(HOLD_CYC - 1);
            default:          tmr_val = '0;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Request context: address, remaining count, last byte, poll bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_addr_q  <= '0;
            last_data_q <= '0;
            left_q      <= '0;
            mode_tog_q  <= 1'b0;
            poll_cnt_q  <= '0;
            met_q       <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (req_valid && page_ok) begin
                        cur_addr_q <= req_addr;
                        left_q     <= req_len;
                        mode_tog_q <= req_toggle;
                        poll_cnt_q <= '0;
                        met_q      <= 1'b0;
                    end
                end
                ST_FETCH: begin
                    if (in_valid) last_data_q <= in_data;
                end
                ST_WHLD: begin
                    if (tmr_last && left_q != LENW'(1)) begin
                        cur_addr_q <= cur_addr_q + AW'(1);
                        left_q     <= left_q - LENW'(1);
                    end
                end
                ST_RSTR: begin
                    if (tmr_last) begin
                        met_q      <= judge_hit;
                        poll_cnt_q <= poll_cnt_q + PCW'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    // Single-cycle result pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            tmo_q  <= 1'b0;
            rej_q  <= 1'b0;
        end else begin
            done_q <= (state_q == ST_RHLD) && tmr_last && met_q;
            tmo_q  <= (state_q == ST_RHLD) && tmr_last && !met_q && at_limit;
            rej_q  <= (state_q == ST_IDLE) && req_valid && !page_ok;
        end
    end

    // Bus strobes decoded from the phase.
    assign req_ready  = (state_q == ST_IDLE);
    assign in_ready   = (state_q == ST_FETCH);
    assign mem_ce_n   = (state_q == ST_IDLE);
    assign mem_we_n   = (state_q != ST_WSTR);
    assign mem_oe_n   = (state_q != ST_RSTR);
    assign mem_dq_oe  = (state_q == ST_WSET) || (state_q == ST_WSTR) || (state_q == ST_WHLD);
    assign mem_addr   = cur_addr_q;
    assign mem_dq_out = last_data_q;
    assign done       = done_q;
    assign timeout    = tmo_q;
    assign reject     = rej_q;

endmodule

// File: rtl/ewp_master_chk.sv
// Protocol checker for ewp_master, attached with bind.
// Watches bus strobes, driver enable and result pulses at the ports only.
// Assumes: the same parameters as the bound instance.
module ewp_master_chk #(
    parameter  int AW           = 11,
    parameter  int DW           = 8,
    parameter  int LOAD_WIN_CYC = 10000,
    localparam int GW           = $clog2(LOAD_WIN_CYC + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_ready,
    input logic [AW-1:0] mem_addr,
    input logic          mem_ce_n,
    input logic          mem_oe_n,
    input logic          mem_we_n,
    input logic [DW-1:0] mem_dq_out,
    input logic          mem_dq_oe,
    input logic          done,
    input logic          timeout,
    input logic          reject
);

    logic [GW-1:0] gap_q;
    logic          armed_q;
    logic          we_q;

    // Count cycles between write strobe falls inside one page load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q   <= '0;
            armed_q <= 1'b0;
            we_q    <= 1'b1;
        end else begin
            if (!mem_oe_n || mem_ce_n) armed_q <= 1'b0;
            else if (!mem_we_n && we_q) armed_q <= 1'b1;
            if (!mem_we_n && we_q) gap_q <= '0;
            else if (gap_q != GW'(LOAD_WIN_CYC)) gap_q <= gap_q + GW'(1);
            we_q <= mem_we_n;
        end
    end

    // R5
    read_bus_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (!mem_dq_oe && mem_we_n && !mem_ce_n));

    // R5
    release_before_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_oe_n) |-> $past(!mem_dq_oe));

    // R3
    write_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!mem_ce_n && mem_oe_n && mem_dq_oe));

    // R3
    write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> ($stable(mem_dq_out) && $stable(mem_addr) && mem_dq_oe));

    // R4
    byte_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && !mem_we_n && we_q) |-> (gap_q < GW'(LOAD_WIN_CYC)));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    timeout_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |=> !timeout);

    // R9
    result_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, timeout, reject}));

    // R9
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_ce_n |-> !req_ready);

    // R2
    reject_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reject |-> $past(req_valid && req_ready));

endmodule

bind ewp_master ewp_master_chk #(
    .AW           (AW),
    .DW           (DW),
    .LOAD_WIN_CYC (LOAD_WIN_CYC)
) u_ewp_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .mem_addr   (mem_addr),
    .mem_ce_n   (mem_ce_n),
    .mem_oe_n   (mem_oe_n),
    .mem_we_n   (mem_we_n),
    .mem_dq_out (mem_dq_out),
    .mem_dq_oe  (mem_dq_oe),
    .done       (done),
    .timeout    (timeout),
    .reject     (reject)
);

// File: tb/ewp_master_bench.sv
// Directed bench for ewp_master with a behavioural self-timed memory model.
module ewp_master_bench;

    localparam int AW = 11;
    localparam int DW = 8;
    localparam int PB = 64;
    localparam int SC = 2;
    localparam int PC = 3;
    localparam int HC = 1;
    localparam int WIN = 50;
    localparam int PL = 20;
    localparam int PERIOD = 1 + SC + PC + HC;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_addr = '0;
    logic [6:0]    req_len = '0;
    logic          req_toggle = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [7:0]    in_data = '0;
    logic [AW-1:0] mem_addr;
    logic          ce_n, oe_n, we_n;
    logic [7:0]    dq_out;
    logic          dq_oe;
    logic [7:0]    rd_q;
    logic          done, timeout, reject;

    ewp_master #(
        .AW(AW), .DW(DW), .PAGE_BYTES(PB), .SETUP_CYC(SC), .PULSE_CYC(PC),
        .HOLD_CYC(HC), .LOAD_WIN_CYC(WIN), .POLL_LIMIT(PL)
    ) u_ewp_master (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_len(req_len), .req_toggle(req_toggle),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .mem_addr(mem_addr), .mem_ce_n(ce_n), .mem_oe_n(oe_n), .mem_we_n(we_n),
        .mem_dq_out(dq_out), .mem_dq_oe(dq_oe), .mem_dq_in(rd_q),
        .done(done), .timeout(timeout), .reject(reject)
    );

    // Memory model state and bus monitors
    logic [7:0] mem_arr [0:(1<<AW)-1];
    int   busy_cfg = 0;
    int   busy_left;
    logic tog;
    int   reads = 0, we_falls = 0, we_bad = 0, gap_bad = 0, ovl_bad = 0;
    int   we_run, gap_run;
    logic we_prev, oe_prev, dq_oe_prev, gap_armed;

    int   vectors = 0;
    int   fails = 0;
    logic [7:0] pat [0:63];

    // Device model: stores write strobes, answers reads, busy for busy_cfg reads after a write
    always @(negedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < (1 << AW); i++) mem_arr[i] = 8'h00;
            busy_left = 0; tog = 1'b0; rd_q = 8'h00;
            we_prev = 1'b1; oe_prev = 1'b1; dq_oe_prev = 1'b0;
            we_run = 0; gap_run = 0; gap_armed = 1'b0;
        end else begin
            gap_run++;
            if (!we_n) begin
                if (!ce_n) mem_arr[mem_addr] = dq_out;
                busy_left = busy_cfg;
                if (we_prev) begin
                    we_falls++;
                    if (gap_armed && gap_run != PERIOD) gap_bad++;
                    gap_armed = 1'b1;
                    gap_run = 0;
                end
                we_run++;
            end else if (!we_prev) begin
                if (we_run != PC) we_bad++;
                we_run = 0;
            end
            if (!oe_n) begin
                if (dq_oe) ovl_bad++;
                if (oe_prev) begin
                    if (dq_oe_prev) ovl_bad++;
                    gap_armed = 1'b0;
                    reads++;
                    if (busy_left > 0) begin
                        rd_q = {~mem_arr[mem_addr][7], tog, mem_arr[mem_addr][5:0]};
                        tog = ~tog;
                        busy_left--;
                    end else begin
                        rd_q = mem_arr[mem_addr];
                    end
                end
            end
            we_prev = we_n; oe_prev = oe_n; dq_oe_prev = dq_oe;
        end
    end

    task automatic check(input bit ok, input string what, input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic send_req(input int addr, input int len, input bit tg);
        req_addr = AW'(addr); req_len = 7'(len); req_toggle = tg; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic feed(input int len);
        in_valid = 1'b1;
        for (int i = 0; i < len; i++) begin
            in_data = pat[i];
            while (!in_ready) @(negedge clk);
            @(negedge clk);
        end
        in_valid = 1'b0;
    endtask

    // kind: 1 done, 2 timeout, 3 reject, 0 nothing seen
    task automatic wait_end(output int kind, output bit saw_in_ready);
        kind = 0; saw_in_ready = 1'b0;
        for (int c = 0; c < 4000; c++) begin
            if (in_ready) saw_in_ready = 1'b1;
            if (done) begin kind = 1; break; end
            if (timeout) begin kind = 2; break; end
            if (reject) begin kind = 3; break; end
            @(negedge clk);
        end
        @(negedge clk);
        check(!done && !timeout && !reject, "R9 result pulse lasts one cycle", {done, timeout, reject}, 0);
    endtask

    function automatic int toggle_reads(input int busy, input bit t0, input bit b6);
        bit tt = t0;
        bit prev = 1'b0;
        bit cur;
        for (int k = 0; k < PL + 8; k++) begin
            if (k < busy) begin cur = tt; tt = ~tt; end
            else cur = b6;
            if (k > 0 && cur == prev) return k + 1;
            prev = cur;
        end
        return -1;
    endfunction

    // Full write-and-poll request with checks on outcome, reads, strobes and memory
    task automatic run_write(input string name, input int addr, input int len, input bit tg,
                             input int busy, input int exp_kind, input int exp_reads);
        int r0, f0, kind, mism;
        bit sawr;
        busy_cfg = busy;
        r0 = reads; f0 = we_falls;
        send_req(addr, len, tg);
        check(req_ready == 1'b0, {name, " R9 req_ready low while busy"}, req_ready, 0);
        feed(len);
        wait_end(kind, sawr);
        check(kind == exp_kind, {name, " R6/R7/R8 outcome"}, kind, exp_kind);
        check(reads - r0 == exp_reads, {name, " R6/R7/R8 read count"}, reads - r0, exp_reads);
        check(we_falls - f0 == len, {name, " R10 bytes written"}, we_falls - f0, len);
        mism = 0;
        for (int i = 0; i < len; i++) if (mem_arr[addr + i] != pat[i]) mism++;
        check(mism == 0, {name, " R3 memory contents"}, mism, 0);
        check(req_ready == 1'b1, {name, " R9 ready after finish"}, req_ready, 1);
    endtask

    task automatic t_reset();
        do_reset();
        check(ce_n && we_n && oe_n, "R1 strobes high", {ce_n, we_n, oe_n}, 7);
        check(!dq_oe, "R1 bus released", dq_oe, 0);
        check(req_ready && !in_ready, "R1 ready state", {req_ready, in_ready}, 2);
        check(!done && !timeout && !reject, "R1 no pulses", {done, timeout, reject}, 0);
    endtask

    task automatic t_byte_data();
        pat[0] = 8'h5A;
        run_write("byte low-top R6", 'h123, 1, 1'b0, 3, 1, 4);
        pat[0] = 8'hC3;
        run_write("byte high-top R6", 'h7FF, 1, 1'b0, 2, 1, 3);
        check(we_bad == 0, "R3 write strobe width", we_bad, 0);
    endtask

    task automatic t_page_toggle();
        int er;
        pat[0] = 8'h11; pat[1] = 8'hA7; pat[2] = 8'h3C; pat[3] = 8'h6E;
        er = toggle_reads(3, tog, pat[3][6]);
        run_write("page toggle R7", 'h244, 4, 1'b1, 3, 1, er);
        check(gap_bad == 0, "R4 byte spacing", gap_bad, 0);
    endtask

    task automatic t_toggle_quick();
        pat[0] = 8'h40;
        run_write("toggle idle R7", 'h010, 1, 1'b1, 0, 1, 2);
    endtask

    task automatic t_full_page();
        for (int i = 0; i < 64; i++) pat[i] = 8'((i * 37 + 5) ^ 8'h96);
        run_write("full page R2", 'h0C0, 64, 1'b0, 1, 1, 2);
        check(gap_bad == 0, "R4 byte spacing on full page", gap_bad, 0);
    endtask

    task automatic t_reject(input string name, input int addr, input int len);
        int r0, f0, kind;
        bit sawr;
        r0 = reads; f0 = we_falls;
        send_req(addr, len, 1'b0);
        wait_end(kind, sawr);
        check(kind == 3, {name, " R2 reject pulse"}, kind, 3);
        check(we_falls == f0 && reads == r0, {name, " R2 no bus cycles"}, (we_falls - f0) + (reads - r0), 0);
        check(!sawr, {name, " R10 no stream request"}, sawr, 0);
    endtask

    task automatic t_timeout();
        pat[0] = 8'h7E;
        run_write("stuck device R8", 'h300, 1, 1'b0, 100, 2, PL);
    endtask

    initial begin
        t_reset();
        t_byte_data();
        t_page_toggle();
        t_toggle_quick();
        t_full_page();
        t_reject("cross page", 'h03E, 4);
        t_reject("zero length", 'h100, 0);
        t_reject("over length", 'h000, 65);
        t_timeout();
        check(ovl_bad == 0, "R5 bus released before and during reads", ovl_bad, 0);
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule